// File: doc/BRIEF.md
# Conversion Result, Status and Interrupt Register Bank

This block sits behind a converter sequencer and holds what the sequencer produces. Each completed conversion arrives as a one-cycle strobe with a channel number, a 12-bit result and a flag saying whether the sequencer is running repeated (burst) conversions. The bank keeps one data register per channel and one global data register that always holds the most recent result together with its channel number. Every data register carries a done flag and an overrun flag.

Software reaches the bank through a simple register port: one address, a read strobe, a write strobe, write data and registered read data. Reading a data register hands back its contents and clears its flags in the same cycle. A status word shows all per-channel flags at once, so they can be polled without side effects. An enable register picks which done flags may drive the single level-sensitive interrupt output.

Address map (word addresses on `reg_addr`): 0 to 7 are the channel data registers, 8 is the global data register, 9 is the status word, 10 is the interrupt enable register. All other addresses read as zero and ignore writes.

Top module: `conv_result_bank`

## Requirements
- R1: A channel data register (address equal to the channel number, 0 to 7) reads with the result in bits 15:4, the overrun flag in bit 30, the done flag in bit 31 and all other bits zero.
- R2: The global data register (address 8) reads with the same result, overrun and done fields as R1, plus the channel number of the latest result in bits 26:24; other bits are zero.
- R3: A completion strobe sets the done flag of its channel register and of the global register and loads their results; read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read.
- R4: Reading a channel register clears that channel's done and overrun flags only; the global flags and other channels are untouched. Reading the global register clears only the global flags. The stored results stay.
- R5: An overrun flag sets when a completion with the burst flag high lands in a register whose done flag is still set; a completion with the burst flag low never sets overrun. An overrun flag is only ever set while its done flag is set.
- R6: The status word (address 9) reads with the channel done flags in bits 7:0, the channel overrun flags in bits 15:8 and the interrupt flag in bit 16; reading it clears nothing.
- R7: The enable register (address 10) is read/write, bits 7:0 enabling the per-channel done flags and bit 8 the global done flag; it resets to zero, and writes to any other address change nothing. Unmapped addresses read as zero.
- R8: The interrupt output is registered: one cycle after the flags change it equals the OR of every enabled channel done flag and the enabled global done flag, and it falls one cycle after reads clear those flags.
- R9: When a completion and a read of the same data register fall in one cycle, the read returns the old contents, the done flag stays set with the new result, and the overrun flag ends cleared because the old result was delivered.
- R10: After synchronous reset all flags, results, the enable register, the read data and the interrupt output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | One-cycle strobe: a conversion completed |
| cmp_chan | input | 3 | Channel of the completed conversion |
| cmp_result | input | 12 | Result of the completed conversion |
| cmp_burst | input | 1 | Sequencer is in repeated-conversion mode |
| reg_addr | input | 4 | Register word address |
| reg_rd | input | 1 | Read strobe, side effects apply in this cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The two functions that can collide are the arrival of a completion and a clearing read of the same data register, both for a channel register and for the global register. The bench provokes this by raising the completion strobe and the read strobe in one cycle for the same target. It judges the result by checking that the read returned the pre-update contents with overrun low, and that a follow-up read shows the new result with done set and overrun cleared, while a register not read in that cycle records the overrun as usual.

// File: rtl/conv_regs_pkg.sv
package conv_regs_pkg;

  // Field positions inside a data word (decoded by software).
  localparam int DONE_BIT = 31;
  localparam int OVR_BIT  = 30;
  localparam int TAG_LSB  = 24;
  localparam int RES_LSB  = 4;

  // Flag pair kept for every data register.
  typedef struct packed {
    logic done;
    logic ovr;
  } flag_t;

  // Register target selected by the address decoder.
  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_CHAN   = 3'd1,
    SEL_GLOBAL = 3'd2,
    SEL_STATUS = 3'd3,
    SEL_ENABLE = 3'd4
  } sel_t;

endpackage

// File: rtl/result_slot.sv
// One data register: stored result plus done/overrun flags.
// A load in the same cycle as a clearing read wins for done; overrun is
// dropped because the previous result is being delivered by that read.
module result_slot
  import conv_regs_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             burst,
  input  logic [RES_W-1:0] res_in,
  input  logic             rd_hit,
  output flag_t            flags,
  output logic [RES_W-1:0] res_q
);

  flag_t flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      res_q   <= '0;
    end else begin
      if (load) begin
        res_q        <= res_in;
        flags_q.done <= 1'b1;
        flags_q.ovr  <= ~rd_hit & (flags_q.ovr | (burst & flags_q.done));
      end else if (rd_hit) begin
        flags_q.done <= 1'b0;
        flags_q.ovr  <= 1'b0;
      end
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/reg_decode.sv
// Address decode for the register port.
module reg_decode
  import conv_regs_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output sel_t              sel,
  output logic [CH_W-1:0]   ch_idx,
  output logic [NUM_CH-1:0] ch_rd_hit,
  output logic              g_rd_hit,
  output logic              en_wr
);

  localparam int GLOBAL_ADDR = NUM_CH;
  localparam int STATUS_ADDR = NUM_CH + 1;
  localparam int ENABLE_ADDR = NUM_CH + 2;

  always_comb begin
    if (addr < ADDR_W'(NUM_CH))                 sel = SEL_CHAN;
    else if (addr == ADDR_W'(GLOBAL_ADDR))      sel = SEL_GLOBAL;
    else if (addr == ADDR_W'(STATUS_ADDR))      sel = SEL_STATUS;
    else if (addr == ADDR_W'(ENABLE_ADDR))      sel = SEL_ENABLE;
    else                                        sel = SEL_NONE;
  end

  assign ch_idx = addr[CH_W-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign ch_rd_hit[i] = rd && (sel == SEL_CHAN) && (ch_idx == CH_W'(i));
  end

  assign g_rd_hit = rd && (sel == SEL_GLOBAL);
  assign en_wr    = wr && (sel == SEL_ENABLE);

endmodule

// File: rtl/irq_gen.sv
// Masked OR of done flags; pending level is combinational, output registered.
module irq_gen #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] done_vec,
  input  logic              g_done,
  input  logic [NUM_CH:0]   enable,
  output logic              pend,
  output logic              irq_q
);

  assign pend = (|(done_vec & enable[NUM_CH-1:0])) | (g_done & enable[NUM_CH]);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend;
  end

endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
  import conv_regs_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [CH_W-1:0]   cmp_chan,
  input  logic [RES_W-1:0]  cmp_result,
  input  logic              cmp_burst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int STAT_IRQ_BIT = 2 * NUM_CH;

  // Decode
  sel_t              sel;
  logic [CH_W-1:0]   ch_idx;
  logic [NUM_CH-1:0] ch_rd_hit;
  logic              g_rd_hit;
  logic              en_wr;

  reg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr      (reg_addr),
    .rd        (reg_rd),
    .wr        (reg_wr),
    .sel       (sel),
    .ch_idx    (ch_idx),
    .ch_rd_hit (ch_rd_hit),
    .g_rd_hit  (g_rd_hit),
    .en_wr     (en_wr)
  );

  // Per-channel slots
  flag_t             ch_flags [NUM_CH];
  logic [RES_W-1:0]  ch_res   [NUM_CH];
  logic [NUM_CH-1:0] done_vec;
  logic [NUM_CH-1:0] ovr_vec;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    result_slot #(.RES_W(RES_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .load   (cmp_valid && (cmp_chan == CH_W'(i))),
      .burst  (cmp_burst),
      .res_in (cmp_result),
      .rd_hit (ch_rd_hit[i]),
      .flags  (ch_flags[i]),
      .res_q  (ch_res[i])
    );
    assign done_vec[i] = ch_flags[i].done;
    assign ovr_vec[i]  = ch_flags[i].ovr;
  end

  // Global slot and its channel tag
  flag_t            g_flags;
  logic [RES_W-1:0] g_res;
  logic [CH_W-1:0]  g_tag;
  logic             g_done;

  result_slot #(.RES_W(RES_W)) u_gslot (
    .clk    (clk),
    .rst    (rst),
    .load   (cmp_valid),
    .burst  (cmp_burst),
    .res_in (cmp_result),
    .rd_hit (g_rd_hit),
    .flags  (g_flags),
    .res_q  (g_res)
  );

  assign g_done = g_flags.done;

  always_ff @(posedge clk) begin
    if (rst)            g_tag <= '0;
    else if (cmp_valid) g_tag <= cmp_chan;
  end

  // Interrupt enable register
  logic [NUM_CH:0] enable_q;

  always_ff @(posedge clk) begin
    if (rst)        enable_q <= '0;
    else if (en_wr) enable_q <= reg_wdata[NUM_CH:0];
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_CH+1];

  // Interrupt
  logic pend;

  irq_gen #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .done_vec (done_vec),
    .g_done   (g_done),
    .enable   (enable_q),
    .pend     (pend),
    .irq_q    (irq)
  );

  // Read data
  function automatic logic [DATA_W-1:0] pack_word(
    input flag_t            f,
    input logic [CH_W-1:0]  tag,
    input logic [RES_W-1:0] res
  );
    logic [DATA_W-1:0] w;
    w                    = '0;
    w[DONE_BIT]          = f.done;
    w[OVR_BIT]           = f.ovr;
    w[TAG_LSB +: CH_W]   = tag;
    w[RES_LSB +: RES_W]  = res;
    return w;
  endfunction

  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_CHAN:   rd_word = pack_word(ch_flags[ch_idx], '0, ch_res[ch_idx]);
      SEL_GLOBAL: rd_word = pack_word(g_flags, g_tag, g_res);
      SEL_STATUS: begin
        rd_word[NUM_CH-1:0]      = done_vec;
        rd_word[NUM_CH +: NUM_CH] = ovr_vec;
        rd_word[STAT_IRQ_BIT]     = pend;
      end
      SEL_ENABLE: rd_word[NUM_CH:0] = enable_q;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

endmodule

// File: rtl/conv_result_bank_chk.sv
module conv_result_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic                clk,
  input logic                rst,
  input logic                cmp_valid,
  input logic [CH_W-1:0]     cmp_chan,
  input logic                cmp_burst,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [2*NUM_CH-1:0] stat_bits,
  input logic                irq,
  input logic [NUM_CH-1:0]   done_vec,
  input logic [NUM_CH-1:0]   ovr_vec,
  input logic                g_done
);

  localparam int STATUS_ADDR = NUM_CH + 1;

  logic [CH_W-1:0] last_cmp_ch;
  logic [CH_W-1:0] last_rd_ch;

  always_ff @(posedge clk) begin
    last_cmp_ch <= cmp_chan;
    last_rd_ch  <= reg_addr[CH_W-1:0];
  end

  AST_DONE_ON_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> (done_vec[last_cmp_ch] && g_done));  // R3

  AST_READ_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr < ADDR_W'(NUM_CH)) &&
     !(cmp_valid && (cmp_chan == reg_addr[CH_W-1:0])))
    |=> !done_vec[last_rd_ch]);  // R4

  AST_OVR_NEEDS_BURST: assert property (@(posedge clk) disable iff (rst)
    (|(ovr_vec & ~$past(ovr_vec))) |-> $past(cmp_valid && cmp_burst));  // R5

  AST_OVR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    ((ovr_vec & ~done_vec) == '0));  // R5

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == ADDR_W'(STATUS_ADDR)))
    |=> (stat_bits == {$past(ovr_vec), $past(done_vec)}));  // R6

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((|done_vec) || g_done));  // R8

endmodule

bind conv_result_bank conv_result_bank_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmp_valid (cmp_valid),
  .cmp_chan  (cmp_chan),
  .cmp_burst (cmp_burst),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .stat_bits (reg_rdata[2*NUM_CH-1:0]),
  .irq       (irq),
  .done_vec  (done_vec),
  .ovr_vec   (ovr_vec),
  .g_done    (g_done)
);

// File: tb/sim_conv_result_bank.sv
`timescale 1ns/1ps
module sim_conv_result_bank;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmp_valid;
  logic [2:0]  cmp_chan;
  logic [11:0] cmp_result;
  logic        cmp_burst;
  logic [3:0]  reg_addr;
  logic        reg_rd;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  conv_result_bank u0 (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_chan(cmp_chan), .cmp_result(cmp_result), .cmp_burst(cmp_burst),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Expected word builders, from R1 and R2 field positions.
  function automatic logic [31:0] chan_word(bit done, bit ovr, logic [11:0] res);
    return {done, ovr, 14'd0, res, 4'd0};
  endfunction

  function automatic logic [31:0] glob_word(bit done, bit ovr, logic [2:0] ch, logic [11:0] res);
    return {done, ovr, 3'd0, ch, 8'd0, res, 4'd0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic complete(logic [2:0] ch, logic [11:0] res, bit burst);
    cmp_valid = 1; cmp_chan = ch; cmp_result = res; cmp_burst = burst;
    @(negedge clk);
    cmp_valid = 0;
  endtask

  task automatic read_reg(logic [3:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 0;
  endtask

  task automatic write_reg(logic [3:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10 irq after reset", {31'd0, irq}, 32'd0);
    check("R10 rdata after reset", reg_rdata, 32'd0);
    read_reg(4'd0, d);  check("R10 ch0 after reset", d, 32'd0);
    read_reg(4'd9, d);  check("R10 status after reset", d, 32'd0);
    read_reg(4'd10, d); check("R10 enable after reset", d, 32'd0);
  endtask

  task automatic t_single;
    logic [31:0] d;
    complete(3'd3, 12'hABC, 0);
    read_reg(4'd3, d); check("R1 R3 ch3 done", d, chan_word(1, 0, 12'hABC));
    read_reg(4'd3, d); check("R4 ch3 cleared, result kept", d, chan_word(0, 0, 12'hABC));
    read_reg(4'd8, d); check("R2 R4 global untouched by ch read", d, glob_word(1, 0, 3'd3, 12'hABC));
    read_reg(4'd8, d); check("R4 global cleared", d, glob_word(0, 0, 3'd3, 12'hABC));
    // hold: rdata stays without a read
    @(negedge clk);
    check("R3 rdata holds", reg_rdata, glob_word(0, 0, 3'd3, 12'hABC));
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    complete(3'd5, 12'h111, 1);
    complete(3'd5, 12'h222, 1);
    read_reg(4'd9, d); check("R5 R6 status shows overrun", d, 32'h0000_2020);
    read_reg(4'd9, d); check("R6 status read clears nothing", d, 32'h0000_2020);
    read_reg(4'd5, d); check("R5 ch5 overrun", d, chan_word(1, 1, 12'h222));
    read_reg(4'd8, d); check("R5 global overrun", d, glob_word(1, 1, 3'd5, 12'h222));
    read_reg(4'd9, d); check("R4 status after reads", d, 32'd0);
  endtask

  task automatic t_no_burst;
    logic [31:0] d;
    complete(3'd1, 12'h0F0, 0);
    complete(3'd1, 12'h0F1, 0);
    read_reg(4'd1, d); check("R5 no overrun without burst", d, chan_word(1, 0, 12'h0F1));
    read_reg(4'd8, d); check("R5 global no overrun without burst", d, glob_word(1, 0, 3'd1, 12'h0F1));
  endtask

  task automatic t_irq;
    logic [31:0] d;
    write_reg(4'd10, 32'h0000_0004);
    read_reg(4'd10, d); check("R7 enable readback", d, 32'h0000_0004);
    complete(3'd6, 12'h066, 0);
    @(negedge clk);
    check("R8 masked channel no irq", {31'd0, irq}, 32'd0);
    complete(3'd2, 12'h022, 0);
    check("R8 irq not before one cycle", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R8 enabled channel irq", {31'd0, irq}, 32'd1);
    read_reg(4'd9, d); check("R6 status interrupt flag", d, 32'h0001_0044);
    read_reg(4'd2, d);
    @(negedge clk);
    check("R8 irq drops after read", {31'd0, irq}, 32'd0);
    write_reg(4'd10, 32'h0000_0100);
    @(negedge clk);
    check("R8 global enable irq", {31'd0, irq}, 32'd1);
    read_reg(4'd8, d);
    @(negedge clk);
    check("R8 irq drops after global read", {31'd0, irq}, 32'd0);
    read_reg(4'd6, d);
    write_reg(4'd12, 32'h0000_01FF);
    read_reg(4'd10, d); check("R7 write elsewhere ignored", d, 32'h0000_0100);
    read_reg(4'd12, d); check("R7 unmapped reads zero", d, 32'd0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    complete(3'd4, 12'h333, 1);
    // completion and read of ch4 in one cycle
    cmp_valid = 1; cmp_chan = 3'd4; cmp_result = 12'h444; cmp_burst = 1;
    reg_rd = 1; reg_addr = 4'd4;
    @(negedge clk);
    cmp_valid = 0; reg_rd = 0;
    check("R9 collide read returns old", reg_rdata, chan_word(1, 0, 12'h333));
    read_reg(4'd4, d); check("R9 collide done kept, overrun cleared", d, chan_word(1, 0, 12'h444));
    // completion and global read in one cycle
    cmp_valid = 1; cmp_chan = 3'd0; cmp_result = 12'h555; cmp_burst = 1;
    reg_rd = 1; reg_addr = 4'd8;
    @(negedge clk);
    cmp_valid = 0; reg_rd = 0;
    check("R9 global collide returns old", reg_rdata, glob_word(1, 1, 3'd4, 12'h444));
    read_reg(4'd8, d); check("R9 global collide new result", d, glob_word(1, 0, 3'd0, 12'h555));
    read_reg(4'd0, d); check("R1 ch0 after collide", d, chan_word(1, 0, 12'h555));
  endtask

  initial begin
    rst = 1; cmp_valid = 0; cmp_chan = 0; cmp_result = 0; cmp_burst = 0;
    reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_overrun();
    t_no_burst();
    t_irq();
    t_collide();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule